// File: doc/BRIEF.md
# Serial Configuration Loader

This block is the host-side controller that loads a programmable logic device over a one-bit serial configuration link, with the host supplying all the clocking. A byte source feeds it through a valid/ready handshake. On the device side it drives an active-low program request, a configuration clock and a serial data line. It watches two open-drain status lines from the device: an active-low init line and a done line.

A run begins with a start command. The controller pulls the program request low for at least a set number of cycles. It then waits until the device releases init. After that it shifts each byte out, most significant bit first, one bit per configuration clock. Once the last byte has gone, it keeps the clock running until done rises. The device signals a corrupted load by pulling init low during the load. The controller also gives up if init never rises, or if done stays low for too many extra clocks. The result is left on the status outputs until the next start.

Top module: `serial_cfg_host`

## Requirements
- R1: After reset, progN=1, cfgClk=0, srcReady=0, busy=0, doneOk=0 and cfgError=0.
- R2: A start command drives progN low for exactly PROG_CYCLES cycles, or for longer while start stays high.
- R3: No rising edge of cfgClk occurs while initN has been low for more than four consecutive cycles.
- R4: If initN stays low for INIT_TIMEOUT cycles after progN is released, the run ends with cfgError=1 and errCode=1. No clock is produced. A value of 0 disables this limit.
- R5: Each byte leaves on cfgDin most significant bit first, one bit per rising edge of cfgClk. cfgDin holds steady while cfgClk is high.
- R6: While loading, cfgClk stays high for CLK_DIV/2 cycles and low for at least CLK_DIV-CLK_DIV/2 cycles.
- R7: srcReady is high only while the controller waits for a byte and init is high. One byte is taken for each cycle with srcValid and srcReady both high. srcLast marks the final byte.
- R8: initN falling low after it went high, during the load or the trailing clocks, stops cfgClk and returns to idle with cfgError=1 and errCode=2.
- R9: After the final bit, cfgClk keeps running until doneIn is seen high. The run then ends with doneOk=1. A done seen in a high phase allows no further rising edge.
- R10: If doneIn is not seen within DONE_EXTRA trailing clock pulses, exactly DONE_EXTRA pulses are issued and the run ends with cfgError=1 and errCode=3.
- R11: doneOk, cfgError and errCode hold their values until the next start, which clears them. doneOk and cfgError are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command; holding it stretches the program pulse |
| srcData | input | DATA_W | Byte from the source |
| srcValid | input | 1 | srcData is valid |
| srcLast | input | 1 | Current byte is the final one |
| srcReady | output | 1 | Controller accepts a byte this cycle |
| progN | output | 1 | Active-low program request to the device |
| cfgClk | output | 1 | Configuration clock to the device |
| cfgDin | output | 1 | Serial configuration data |
| initN | input | 1 | Open-drain init status, low while clearing or on error |
| doneIn | input | 1 | Open-drain done status |
| busy | output | 1 | A run is in progress |
| doneOk | output | 1 | Last run completed with done seen |
| cfgError | output | 1 | Last run failed |
| errCode | output | 2 | 0 none, 1 init stuck, 2 init fell, 3 done missing |

## Verification
The bench models the device. It holds init low for an adjustable time after the program pulse, can pull init low in the middle of a byte, and raises done after a chosen number of trailing clocks. Every bit seen at a clock rise is checked against a queue of expected bits. A controller that shifted the least significant bit first, or dropped a bit at a byte boundary, would fail those checks. The bench counts trailing pulses exactly, so a controller that stops one pulse early or runs one pulse past the done limit is caught. It also confirms that the clock stays silent after an abort, which a controller that only raised the flag would not do. It checks the program pulse width both at its minimum and when start is held longer, and it confirms that a stuck init line ends in an error with no clock ever issued.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_FETCH,
    ST_SHIFT,
    ST_FLUSH
  } hostState_e;

  typedef enum logic [1:0] {
    ERR_NONE       = 2'd0,
    ERR_INIT_STUCK = 2'd1,
    ERR_INIT_FELL  = 2'd2,
    ERR_NO_DONE    = 2'd3
  } errKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;    // clear the general wait counter
    logic cntEn;     // advance the general wait counter
    logic loadByte;  // capture a byte into the shifter
    logic clkRun;    // run the configuration clock divider
    logic flushing;  // trailing clocks after the final bit
  } hostStrobe_t;

endpackage

// File: rtl/cfg_host_dp.sv
module cfg_host_dp
  import cfg_host_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLK_DIV      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int INIT_TIMEOUT = 1000,
  parameter int DONE_EXTRA   = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [DATA_W-1:0] srcData,
  input  logic              initN,
  input  logic              doneIn,
  output logic              cfgClk,
  output logic              cfgDin,
  output logic              initHi,
  output logic              doneHi,
  output logic              byteEnd,
  output logic              progMet,
  output logic              initExpired,
  output logic              extraExpired
);

  localparam int LOW_CYC = CLK_DIV - CLK_DIV / 2;
  localparam int DIVW    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int MAXWAIT = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int CW      = $clog2(MAXWAIT + 1);
  localparam int EW      = $clog2(DONE_EXTRA + 1);
  localparam int BW      = $clog2(DATA_W + 1);

  // status line synchronisers
  logic [SYNC_STAGES-1:0] initPipe, donePipe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPipe <= '0;
      donePipe <= '0;
    end else begin
      initPipe <= {initPipe[SYNC_STAGES-2:0], initN};
      donePipe <= {donePipe[SYNC_STAGES-2:0], doneIn};
    end
  end
  assign initHi = initPipe[SYNC_STAGES-1];
  assign doneHi = donePipe[SYNC_STAGES-1];

  // clock divider: low phase first, then high phase
  logic [DIVW-1:0] divCnt;
  logic            fallTick, riseSet, clkQ;
  assign fallTick = strb.clkRun && (divCnt == DIVW'(CLK_DIV - 1));
  assign riseSet  = strb.clkRun && (divCnt == DIVW'(LOW_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      clkQ   <= 1'b0;
    end else if (!strb.clkRun) begin
      divCnt <= '0;
      clkQ   <= 1'b0;
    end else begin
      divCnt <= fallTick ? '0 : divCnt + DIVW'(1);
      if (riseSet)       clkQ <= 1'b1;
      else if (fallTick) clkQ <= 1'b0;
    end
  end
  assign cfgClk = clkQ;

  // shifter, most significant bit leads; ones fill behind
  logic [DATA_W-1:0] shReg;
  logic [BW-1:0]     bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '1;
      bitCnt <= '0;
    end else if (strb.loadByte) begin
      shReg  <= srcData;
      bitCnt <= BW'(DATA_W);
    end else if (fallTick) begin
      shReg  <= {shReg[DATA_W-2:0], 1'b1};
      if (bitCnt != '0) bitCnt <= bitCnt - BW'(1);
    end
  end
  assign cfgDin  = shReg[DATA_W-1];
  assign byteEnd = fallTick && (bitCnt == BW'(1));

  // shared wait counter for the program pulse and the init wait
  logic [CW-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  waitCnt <= '0;
    else if (strb.clrCnt)                       waitCnt <= '0;
    else if (strb.cntEn && waitCnt != CW'(MAXWAIT)) waitCnt <= waitCnt + CW'(1);
  end
  assign progMet = (waitCnt >= CW'(PROG_CYCLES - 1));

  generate
    if (INIT_TIMEOUT == 0) begin : g_noInitLimit
      assign initExpired = 1'b0;
    end else begin : g_initLimit
      assign initExpired = (waitCnt >= CW'(INIT_TIMEOUT - 1));
    end
  endgenerate

  // trailing pulse counter
  logic [EW-1:0] extraCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  extraCnt <= '0;
    else if (!strb.flushing)    extraCnt <= '0;
    else if (fallTick && extraCnt != EW'(DONE_EXTRA)) extraCnt <= extraCnt + EW'(1);
  end
  assign extraExpired = strb.flushing && fallTick && (extraCnt == EW'(DONE_EXTRA - 1));

endmodule

// File: rtl/cfg_host_ctrl.sv
module cfg_host_ctrl
  import cfg_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        srcValid,
  input  logic        srcLast,
  input  logic        initHi,
  input  logic        doneHi,
  input  logic        byteEnd,
  input  logic        progMet,
  input  logic        initExpired,
  input  logic        extraExpired,
  output hostStrobe_t strb,
  output logic        srcReady,
  output logic        progN,
  output logic        busy,
  output logic        doneOk,
  output logic        cfgError,
  output logic [1:0]  errCode
);

  hostState_e state, nextState;
  logic       lastQ;
  logic       clrStatus, setOk, setErr;
  errKind_e   errKind, errNext;

  always_comb begin
    strb      = '0;
    nextState = state;
    clrStatus = 1'b0;
    setOk     = 1'b0;
    setErr    = 1'b0;
    errNext   = ERR_NONE;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clrCnt = 1'b1;
          clrStatus   = 1'b1;
          nextState   = ST_PROG;
        end
      end
      ST_PROG: begin
        strb.cntEn = 1'b1;
        if (progMet && !start) begin
          strb.clrCnt = 1'b1;
          nextState   = ST_WAIT_INIT;
        end
      end
      ST_WAIT_INIT: begin
        strb.cntEn = 1'b1;
        if (initHi) begin
          nextState = ST_FETCH;
        end else if (initExpired) begin
          setErr    = 1'b1;
          errNext   = ERR_INIT_STUCK;
          nextState = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (!initHi) begin
          setErr    = 1'b1;
          errNext   = ERR_INIT_FELL;
          nextState = ST_IDLE;
        end else if (srcValid) begin
          strb.loadByte = 1'b1;
          nextState     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        strb.clkRun = 1'b1;
        if (!initHi) begin
          setErr    = 1'b1;
          errNext   = ERR_INIT_FELL;
          nextState = ST_IDLE;
        end else if (byteEnd) begin
          nextState = lastQ ? ST_FLUSH : ST_FETCH;
        end
      end
      ST_FLUSH: begin
        strb.clkRun   = 1'b1;
        strb.flushing = 1'b1;
        if (!initHi) begin
          setErr    = 1'b1;
          errNext   = ERR_INIT_FELL;
          nextState = ST_IDLE;
        end else if (doneHi) begin
          setOk     = 1'b1;
          nextState = ST_IDLE;
        end else if (extraExpired) begin
          setErr    = 1'b1;
          errNext   = ERR_NO_DONE;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastQ    <= 1'b0;
      doneOk   <= 1'b0;
      cfgError <= 1'b0;
      errKind  <= ERR_NONE;
    end else begin
      state <= nextState;
      if (strb.loadByte) lastQ <= srcLast;
      if (clrStatus) begin
        doneOk   <= 1'b0;
        cfgError <= 1'b0;
        errKind  <= ERR_NONE;
      end else if (setOk) begin
        doneOk <= 1'b1;
      end else if (setErr) begin
        cfgError <= 1'b1;
        errKind  <= errNext;
      end
    end
  end

  assign srcReady = (state == ST_FETCH) && initHi;
  assign progN    = (state != ST_PROG);
  assign busy     = (state != ST_IDLE);
  assign errCode  = errKind;

endmodule

// File: rtl/serial_cfg_host.sv
module serial_cfg_host
  import cfg_host_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLK_DIV      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int INIT_TIMEOUT = 1000,
  parameter int DONE_EXTRA   = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  input  logic              srcLast,
  output logic              srcReady,
  output logic              progN,
  output logic              cfgClk,
  output logic              cfgDin,
  input  logic              initN,
  input  logic              doneIn,
  output logic              busy,
  output logic              doneOk,
  output logic              cfgError,
  output logic [1:0]        errCode
);

  hostStrobe_t strb;
  logic initHi, doneHi, byteEnd, progMet, initExpired, extraExpired;

  cfg_host_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .srcValid     (srcValid),
    .srcLast      (srcLast),
    .initHi       (initHi),
    .doneHi       (doneHi),
    .byteEnd      (byteEnd),
    .progMet      (progMet),
    .initExpired  (initExpired),
    .extraExpired (extraExpired),
    .strb         (strb),
    .srcReady     (srcReady),
    .progN        (progN),
    .busy         (busy),
    .doneOk       (doneOk),
    .cfgError     (cfgError),
    .errCode      (errCode)
  );

  cfg_host_dp #(
    .DATA_W       (DATA_W),
    .CLK_DIV      (CLK_DIV),
    .PROG_CYCLES  (PROG_CYCLES),
    .INIT_TIMEOUT (INIT_TIMEOUT),
    .DONE_EXTRA   (DONE_EXTRA),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .srcData      (srcData),
    .initN        (initN),
    .doneIn       (doneIn),
    .cfgClk       (cfgClk),
    .cfgDin       (cfgDin),
    .initHi       (initHi),
    .doneHi       (doneHi),
    .byteEnd      (byteEnd),
    .progMet      (progMet),
    .initExpired  (initExpired),
    .extraExpired (extraExpired)
  );

endmodule

// File: rtl/cfg_host_chk.sv
module cfg_host_chk #(
  parameter int CLK_DIV     = 4,
  parameter int PROG_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       srcReady,
  input logic       progN,
  input logic       cfgClk,
  input logic       cfgDin,
  input logic       initN,
  input logic       busy,
  input logic       doneOk,
  input logic       cfgError,
  input logic [1:0] errCode
);

  localparam int HIGH_CYC = CLK_DIV / 2;

  logic [15:0] progLowCnt, hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progLowCnt <= '0;
      hiCnt      <= '0;
    end else begin
      progLowCnt <= !progN ? ((progLowCnt == 16'hFFFF) ? progLowCnt : progLowCnt + 16'd1) : '0;
      hiCnt      <= cfgClk ? ((hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 16'd1) : '0;
    end
  end

  p_prog_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progN) |-> progLowCnt >= 16'(PROG_CYCLES));

  p_no_clk_init_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!initN && !$past(initN) && !$past(initN, 2) && !$past(initN, 3) && !$past(initN, 4))
      |-> !cfgClk);

  p_din_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> $stable(cfgDin));

  p_clk_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cfgClk) && busy) |-> hiCnt == 16'(HIGH_CYC));

  p_ready_clk_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> !cfgClk);

  p_idle_no_clk_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> !cfgClk);

  p_status_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && !$past(start)) |->
      ($stable(doneOk) && $stable(cfgError) && $stable(errCode)));

  p_ok_err_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && cfgError));

endmodule

bind serial_cfg_host cfg_host_chk #(
  .CLK_DIV     (CLK_DIV),
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .srcReady (srcReady),
  .progN    (progN),
  .cfgClk   (cfgClk),
  .cfgDin   (cfgDin),
  .initN    (initN),
  .busy     (busy),
  .doneOk   (doneOk),
  .cfgError (cfgError),
  .errCode  (errCode)
);

// File: tb/sim_serial_cfg_host.sv
`timescale 1ns/1ps
module sim_serial_cfg_host;

  localparam int PROG_CYCLES  = 16;
  localparam int INIT_TIMEOUT = 1000;
  localparam int DONE_EXTRA   = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] srcData = '0;
  logic       srcValid = 1'b0;
  logic       srcLast = 1'b0;
  logic       srcReady, progN, cfgClk, cfgDin, busy, doneOk, cfgError;
  logic [1:0] errCode;
  logic       initN = 1'b1;
  logic       doneIn = 1'b0;

  always #4 clk = ~clk;

  serial_cfg_host u0 (
    .clk(clk), .rstN(rstN), .start(start), .srcData(srcData),
    .srcValid(srcValid), .srcLast(srcLast), .srcReady(srcReady),
    .progN(progN), .cfgClk(cfgClk), .cfgDin(cfgDin), .initN(initN),
    .doneIn(doneIn), .busy(busy), .doneOk(doneOk), .cfgError(cfgError),
    .errCode(errCode)
  );

  int testsRun = 0, testsFail = 0;
  bit expQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model and monitor state
  int  initDelay = 20;
  bit  stuckInit = 0, forceLow = 0;
  int  doneAfter = 0;
  int  relCnt = 0, cyc = 0;
  int  progRun = 0, lastProgLow = 0;
  int  initLowRun = 0, riseCnt = 0, extraRises = 0;
  int  badInitRises = 0, hiRun = 0, badHigh = 0, readyHigh = 0;
  logic prevClk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!progN) progRun++;
    else if (progRun != 0) begin lastProgLow = progRun; progRun = 0; end
    if (!initN) initLowRun++; else initLowRun = 0;
    if (cfgClk && !prevClk) begin
      riseCnt++;
      if (initLowRun >= 5) badInitRises++;
      if (expQ.size() > 0) begin
        bit e;
        e = expQ.pop_front();
        check(cfgDin == e, "R5 bit order", cfgDin, e);
      end else extraRises++;
    end
    if (cfgClk) hiRun++;
    else begin
      if (prevClk && busy && hiRun != 2) badHigh++;
      hiRun = 0;
    end
    if (srcReady && cfgClk) readyHigh++;
    prevClk = cfgClk;
    // device model
    if (!progN) begin
      initN = 1'b0; relCnt = 0; doneIn = 1'b0;
    end else if (stuckInit || forceLow) begin
      initN = 1'b0;
    end else if (!initN) begin
      if (relCnt >= initDelay) initN = 1'b1; else relCnt++;
    end
    if (doneAfter > 0 && progN && extraRises >= doneAfter) doneIn = 1'b1;
  end

  // driver: pushes expected bits, then hands the byte over
  task automatic sendBytes(input int n, input logic [7:0] seed, input int gap);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 37);
      srcData = b; srcLast = (i == n - 1); srcValid = 1'b1;
      while (!srcReady && busy) @(negedge clk);
      if (!busy) begin srcValid = 1'b0; return; end
      for (int k = 7; k >= 0; k--) expQ.push_back(b[k]);
      @(negedge clk);
      srcValid = 1'b0; srcLast = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic startRun(input int hold);
    extraRises = 0;
    start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle(input int limit);
    int c = 0;
    while (busy && c < limit) begin @(negedge clk); c++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin : mainSeq
    int r0, t0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(progN == 1 && cfgClk == 0 && srcReady == 0, "R1 pins", {progN, cfgClk, srcReady}, 3'b100);
    check(busy == 0 && doneOk == 0 && cfgError == 0, "R1 status", {busy, doneOk, cfgError}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // normal load, 5 bytes with gaps, done after 3 trailing clocks
    initDelay = 30; doneAfter = 3;
    startRun(1);
    sendBytes(5, 8'hA5, 3);
    waitIdle(2000);
    check(lastProgLow == PROG_CYCLES, "R2 min pulse", lastProgLow, PROG_CYCLES);
    check(doneOk == 1 && cfgError == 0, "R9 success", {doneOk, cfgError}, 2'b10);
    check(extraRises == 3, "R9 trailing clocks", extraRises, 3);
    check(expQ.size() == 0, "R7 all bytes taken", expQ.size(), 0);
    check(badHigh == 0, "R6 high width", badHigh, 0);
    check(readyHigh == 0, "R7 ready only clk low", readyHigh, 0);
    check(badInitRises == 0, "R3 no clk during init low", badInitRises, 0);
    repeat (20) @(negedge clk);
    check(doneOk == 1 && busy == 0, "R11 status held", doneOk, 1);

    // init falls during the second byte
    doneAfter = 0; initDelay = 10;
    startRun(1);
    r0 = riseCnt;
    fork
      sendBytes(4, 8'h3C, 0);
      begin
        while (riseCnt - r0 < 10) @(negedge clk);
        forceLow = 1;
      end
    join
    waitIdle(200);
    repeat (5) @(negedge clk);
    check(cfgError == 1 && errCode == 2, "R8 init fell code", errCode, 2);
    check(busy == 0 && doneOk == 0, "R8 idle no ok", {busy, doneOk}, 0);
    r0 = riseCnt;
    repeat (30) @(negedge clk);
    check(riseCnt == r0 && cfgClk == 0, "R8 clock stopped", riseCnt - r0, 0);
    expQ.delete();
    forceLow = 0;

    // done never comes
    doneAfter = 0; initDelay = 5;
    startRun(1);
    sendBytes(2, 8'h81, 1);
    waitIdle(4000);
    check(cfgError == 1 && errCode == 3, "R10 done missing code", errCode, 3);
    check(extraRises == DONE_EXTRA, "R10 trailing count", extraRises, DONE_EXTRA);

    // init stuck low
    stuckInit = 1;
    r0 = riseCnt;
    startRun(1);
    t0 = cyc;
    waitIdle(3000);
    check(cfgError == 1 && errCode == 1, "R4 init stuck code", errCode, 1);
    check(cyc - t0 >= INIT_TIMEOUT, "R4 waited long enough", cyc - t0, INIT_TIMEOUT);
    check(riseCnt == r0, "R3 no clock when stuck", riseCnt - r0, 0);
    stuckInit = 0;

    // long program hold; start clears the old error
    doneAfter = 1; initDelay = 8;
    fork
      startRun(40);
      begin
        repeat (3) @(negedge clk);
        check(cfgError == 0 && errCode == 0, "R11 start clears", errCode, 0);
      end
    join
    sendBytes(1, 8'h00, 0);
    waitIdle(2000);
    check(lastProgLow >= 40, "R2 stretched pulse", lastProgLow, 40);
    check(doneOk == 1 && extraRises == 1, "R9 single byte", extraRises, 1);
    check(badHigh == 0 && badInitRises == 0, "R6 R3 final", badHigh + badInitRises, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule